// File: doc/BRIEF.md
# Three-Channel Interleaved Timer Register File

This block is the register front end of a three-channel timer. A single request port (valid, write flag, byte address, write data) reaches a 4 KB window. Registers of one kind are stored as three neighbouring words, one word per channel. The channel is therefore the word offset modulo three, and the register kind is the word offset divided by three. Each channel holds its own configuration and status registers, a behavioural 16-bit counter and an event counter. Each channel drives its own interrupt line.

Writes are trimmed to the width of the target register. The value and event-count registers are read-only. The interrupt status register clears itself when it is read. A read returns its data one cycle after the request. The clear strobe acts in the same cycle as the request, so the data returned is the flag set as it stood before the clear. Any flag raised by the counter in that same cycle is kept.

Top module: `ttc3_regfile`

## Requirements
- R1: For byte address A, the word offset W = A[11:2] selects channel W mod 3 and register kind W div 3. The kind order is: clock setup 0, counter control 1, count value 2, interval 3, compare A 4, compare B 5, compare C 6, interrupt status 7, interrupt enable 8, event control 9, event count 10. An access touches only the selected channel.
- R2: A write keeps only the register's defined bits: 6 bits (mask 0x3F) for clock setup and interrupt enable, 16 bits for interval and the three compare registers, and 3 bits for event control. Counter control stores mask 0x2F, because bit 4 is a one-shot count clear that is never stored.
- R3: After reset every channel's counter control reads 0x21, and every other register reads 0. All irq lines are low and rd_valid is low.
- R4: A read request is answered with rd_valid high and the data on rd_data on the following cycle. When no read was requested in the previous cycle, rd_valid is low and rd_data is 0.
- R5: Reading interrupt status returns the current flags and clears them. A second read returns 0 if no new flag was raised.
- R6: Writes to interrupt status, count value, event count and unmapped words (W >= 33) change nothing. Reads of unmapped words return 0.
- R7: A write to one compare register leaves the other two compare registers unchanged.
- R8: The count value reads as the 16-bit count. Counter control bit 0 = 1 freezes the count, and writing counter control with bit 4 set zeroes it. Event control bit 0 = 1 makes the event count advance once per clock.
- R9: The counter runs when counter control bit 0 = 0. It counts up, or down when bit 2 = 1. With bit 1 = 1 it wraps between 0 and the interval value and sets status bit 0 on each wrap. Otherwise it wraps across 0xFFFF/0 and sets status bit 4. With bit 3 = 1, a running count equal to compare A, B or C sets status bit 1, 2 or 3.
- R10: irq[c] is high exactly when channel c has a status bit that is also set in its interrupt enable register.
- R11: When a flag is raised in the same cycle that a read clears the status, the new flag survives into the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
Two events can fall in the same cycle: a read of a channel's status, which clears it, and that channel's counter raising a new flag. The bench provokes this by setting a zero interval in wrap mode, so the counter wraps on every clock. It then issues two status reads on consecutive cycles. Both reads must return bit 0, which shows that the flag set during the first read's clear cycle was not lost.

// File: rtl/ttc3_pkg.sv
package ttc3_pkg;
   localparam int NUM_KINDS = 11;
   localparam int NUM_MATCH = 3;
   localparam int FLAG_W    = 6;

   typedef enum logic [3:0] {
      K_CLK  = 4'd0,
      K_CTL  = 4'd1,
      K_VAL  = 4'd2,
      K_INTV = 4'd3,
      K_CMPA = 4'd4,
      K_CMPB = 4'd5,
      K_CMPC = 4'd6,
      K_STS  = 4'd7,
      K_IEN  = 4'd8,
      K_EVC  = 4'd9,
      K_EVV  = 4'd10
   } kind_e;

   localparam logic [5:0] CLK_MASK = 6'h3F;
   localparam logic [5:0] CTL_MASK = 6'h2F;
   localparam logic [5:0] IEN_MASK = 6'h3F;
   localparam logic [2:0] EVC_MASK = 3'h7;
   localparam logic [5:0] CTL_RST  = 6'h21;

   localparam int CTL_STOP  = 0;
   localparam int CTL_WRAPI = 1;
   localparam int CTL_DOWN  = 2;
   localparam int CTL_CMPEN = 3;
   localparam int CTL_CLR   = 4;

   localparam int F_WRAPI = 0;
   localparam int F_CMP0  = 1;
   localparam int F_OVF   = 4;
endpackage

// File: rtl/ttc3_decode.sv
module ttc3_decode
   import ttc3_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NUM_CH = 3,
   localparam int WORD_W = ADDR_W - 2,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CH_W-1:0]   ch,
   output kind_e             kind,
   output logic              hit
);
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] quot;

   always_comb begin
      word = addr[ADDR_W-1:2];
      quot = word / WORD_W'(NUM_CH);
      ch   = CH_W'(word % WORD_W'(NUM_CH));
      hit  = (word < WORD_W'(NUM_KINDS * NUM_CH));
      kind = kind_e'(quot[3:0]);
   end
endmodule

// File: rtl/ttc3_counter.sv
module ttc3_counter
   import ttc3_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            wrap_intv,
   input  logic                            down,
   input  logic                            cmp_en,
   input  logic                            zero_cnt,
   input  logic                            ev_run,
   input  logic [CNT_W-1:0]                intv,
   input  logic [NUM_MATCH-1:0][CNT_W-1:0] cmp,
   output logic [CNT_W-1:0]                cnt,
   output logic [CNT_W-1:0]                ev_cnt,
   output logic [FLAG_W-1:0]               flags
);
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      flags   = '0;
      if (run) begin
         if (!down) begin
            if (wrap_intv && cnt == intv) begin
               cnt_nxt        = '0;
               flags[F_WRAPI] = 1'b1;
            end else if (cnt == '1) begin
               cnt_nxt      = '0;
               flags[F_OVF] = 1'b1;
            end else begin
               cnt_nxt = cnt + 1'b1;
            end
         end else if (cnt == '0) begin
            cnt_nxt = wrap_intv ? intv : '1;
            if (wrap_intv) flags[F_WRAPI] = 1'b1;
            else           flags[F_OVF]   = 1'b1;
         end else begin
            cnt_nxt = cnt - 1'b1;
         end
      end
      for (int i = 0; i < NUM_MATCH; i++) begin
         if (run && cmp_en && cnt == cmp[i]) flags[F_CMP0 + i] = 1'b1;
      end
      if (zero_cnt) cnt_nxt = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         ev_cnt <= '0;
      end else begin
         cnt <= cnt_nxt;
         if (ev_run) ev_cnt <= ev_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ttc3_chan.sv
module ttc3_chan
   import ttc3_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  kind_e             kind,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   logic [5:0]                      clk_q, ctl_q, ien_q, sts_q;
   logic [2:0]                      evc_q;
   logic [CNT_W-1:0]                intv_q;
   logic [NUM_MATCH-1:0][CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0]                cnt, ev_cnt;
   logic [FLAG_W-1:0]               flags;
   logic                            zero_cnt, clr_sts;

   assign zero_cnt = wr_en && kind == K_CTL && wdata[CTL_CLR];
   assign clr_sts  = rd_en && kind == K_STS;

   ttc3_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (!ctl_q[CTL_STOP]),
      .wrap_intv(ctl_q[CTL_WRAPI]),
      .down     (ctl_q[CTL_DOWN]),
      .cmp_en   (ctl_q[CTL_CMPEN]),
      .zero_cnt (zero_cnt),
      .ev_run   (evc_q[0]),
      .intv     (intv_q),
      .cmp      (cmp_q),
      .cnt      (cnt),
      .ev_cnt   (ev_cnt),
      .flags    (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_q  <= '0;
         ctl_q  <= CTL_RST;
         ien_q  <= '0;
         sts_q  <= '0;
         evc_q  <= '0;
         intv_q <= '0;
         cmp_q  <= '0;
      end else begin
         sts_q <= (sts_q & {6{!clr_sts}}) | flags;
         if (wr_en) begin
            case (kind)
               K_CLK:  clk_q    <= wdata[5:0] & CLK_MASK;
               K_CTL:  ctl_q    <= wdata[5:0] & CTL_MASK;
               K_INTV: intv_q   <= wdata[CNT_W-1:0];
               K_CMPA: cmp_q[0] <= wdata[CNT_W-1:0];
               K_CMPB: cmp_q[1] <= wdata[CNT_W-1:0];
               K_CMPC: cmp_q[2] <= wdata[CNT_W-1:0];
               K_IEN:  ien_q    <= wdata[5:0] & IEN_MASK;
               K_EVC:  evc_q    <= wdata[2:0] & EVC_MASK;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (kind)
         K_CLK:   rdata = DATA_W'(clk_q);
         K_CTL:   rdata = DATA_W'(ctl_q);
         K_VAL:   rdata = DATA_W'(cnt);
         K_INTV:  rdata = DATA_W'(intv_q);
         K_CMPA:  rdata = DATA_W'(cmp_q[0]);
         K_CMPB:  rdata = DATA_W'(cmp_q[1]);
         K_CMPC:  rdata = DATA_W'(cmp_q[2]);
         K_STS:   rdata = DATA_W'(sts_q);
         K_IEN:   rdata = DATA_W'(ien_q);
         K_EVC:   rdata = DATA_W'(evc_q);
         K_EVV:   rdata = DATA_W'(ev_cnt);
         default: rdata = '0;
      endcase
   end

   assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/ttc3_regfile.sv
module ttc3_regfile
   import ttc3_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] irq
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (CNT_W > DATA_W || CNT_W < 8)
         $error("CNT_W must lie between 8 and DATA_W");
      if (DATA_W < 16)
         $error("DATA_W must hold a 16-bit register");
      if (ADDR_W < 3 || (1 << (ADDR_W - 2)) < NUM_KINDS * NUM_CH)
         $error("address window too small for the register map");
   endgenerate

   logic [CH_W-1:0]   dec_ch;
   kind_e             dec_kind;
   logic              dec_hit;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];
   logic              rd_req;

   assign rd_req = req_valid && !req_write;

   ttc3_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
      .addr(req_addr),
      .ch  (dec_ch),
      .kind(dec_kind),
      .hit (dec_hit)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = req_valid && dec_hit && dec_ch == CH_W'(c);
      ttc3_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chan_i (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_en(sel && req_write),
         .rd_en(sel && !req_write),
         .kind (dec_kind),
         .wdata(req_wdata),
         .rdata(ch_rdata[c]),
         .irq  (irq[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         rd_data  <= (rd_req && dec_hit) ? ch_rdata[dec_ch] : '0;
      end
   end
endmodule

// File: rtl/ttc3_regfile_chk.sv
module ttc3_regfile_chk #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 33
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data
);
   // R4
   rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   // R4
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);

   // R4
   idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);

   // R6
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && int'(req_addr[ADDR_W-1:2]) >= NUM_WORDS)
      |=> rd_data == '0);

   // R8
   upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:16] == '0);
endmodule

bind ttc3_regfile ttc3_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(ttc3_pkg::NUM_KINDS * NUM_CH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .rd_valid (rd_valid),
   .rd_data  (rd_data)
);

// File: tb/ttc3_regfile_tb_top.sv
module ttc3_regfile_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] exp_reg [11][3];

   always #(CLK_PERIOD / 2) clk = ~clk;

   ttc3_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [11:0] adr(int k, int c);
      return 12'((k * 3 + c) * 4);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 rd_valid", 32'(rd_valid), 32'd1);
      d = rd_data;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d, d2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      check("R3 irq", 32'(irq), 32'd0);
      check("R3 rd_valid", 32'(rd_valid), 32'd0);
      for (int c = 0; c < 3; c++) begin
         rd(adr(1, c), d); check("R3 ctl reset", d, 32'h21);
         rd(adr(0, c), d); check("R3 clk reset", d, 32'h0);
         rd(adr(8, c), d); check("R3 ien reset", d, 32'h0);
      end

      // R1 R2 R6 R7 sweep: every word written with a distinct pattern
      for (int k = 0; k < 11; k++)
         for (int c = 0; c < 3; c++) exp_reg[k][c] = (k == 1) ? 32'h21 : 32'h0;
      for (int k = 0; k < 11; k++) begin
         for (int c = 0; c < 3; c++) begin
            logic [31:0] p;
            p = 32'h9E37_0000 ^ (32'(k * 3 + c + 1) * 32'h0001_1357);
            if (k == 1) p = p | 32'h1;
            if (k == 9) p = p & ~32'h1;
            wr(adr(k, c), p);
            case (k)
               0, 8:       exp_reg[k][c] = p & 32'h3F;
               1:          exp_reg[k][c] = p & 32'h2F;
               3, 4, 5, 6: exp_reg[k][c] = p & 32'hFFFF;
               9:          exp_reg[k][c] = p & 32'h7;
               default:    ;
            endcase
         end
      end
      wr(12'h084, 32'hFFFF_FFFF);
      wr(12'hFFC, 32'hFFFF_FFFF);
      for (int k = 0; k < 11; k++)
         for (int c = 0; c < 3; c++) begin
            rd(adr(k, c), d);
            check($sformatf("R1 R2 R6 R7 kind %0d ch %0d", k, c), d, exp_reg[k][c]);
         end
      rd(12'h084, d); check("R6 unmapped 0x084", d, 32'h0);
      rd(12'hFFC, d); check("R6 unmapped 0xFFC", d, 32'h0);
      check("R10 irq quiet", 32'(irq), 32'd0);
      for (int c = 0; c < 3; c++) wr(adr(8, c), 32'h0);

      // R9 interval wrap on ch1, then R5 clear and R8 freeze / zero
      wr(adr(3, 1), 32'd3);
      wr(adr(1, 1), 32'h13);
      wr(adr(1, 1), 32'h02);
      repeat (20) @(negedge clk);
      wr(adr(1, 1), 32'h03);
      rd(adr(7, 1), d); check("R9 interval wrap flag", d, 32'h01);
      rd(adr(7, 1), d); check("R5 cleared on read", d, 32'h00);
      rd(adr(2, 1), d);
      check("R8 count within interval", 32'(d <= 32'd3), 32'd1);
      repeat (5) @(negedge clk);
      rd(adr(2, 1), d2); check("R8 count frozen", d2, d);
      wr(adr(1, 1), 32'h13);
      rd(adr(2, 1), d); check("R8 count zeroed", d, 32'h0);

      // R9 compare B on ch2
      wr(adr(4, 2), 32'h1000);
      wr(adr(5, 2), 32'd5);
      wr(adr(6, 2), 32'h2000);
      wr(adr(1, 2), 32'h19);
      wr(adr(1, 2), 32'h08);
      repeat (20) @(negedge clk);
      wr(adr(1, 2), 32'h09);
      rd(adr(7, 2), d); check("R9 compare B flag", d, 32'h04);
      rd(adr(4, 2), d); check("R7 compare A kept", d, 32'h1000);

      // R9 down overflow on ch0, R10 irq
      wr(adr(1, 0), 32'h15);
      wr(adr(1, 0), 32'h04);
      repeat (10) @(negedge clk);
      wr(adr(1, 0), 32'h05);
      check("R10 irq masked", 32'(irq), 32'd0);
      wr(adr(8, 0), 32'h10);
      check("R10 irq raised", 32'(irq), 32'b001);
      rd(adr(2, 0), d);
      check("R8 count wrapped below zero", 32'(d > 32'hFF00 && d <= 32'hFFFF), 32'd1);
      wr(adr(7, 0), 32'h0);
      check("R6 status write ignored", 32'(irq), 32'b001);
      rd(adr(7, 0), d); check("R9 overflow flag", d, 32'h10);
      check("R10 irq after clear", 32'(irq), 32'd0);

      // R8 event count
      wr(adr(10, 0), 32'h1234);
      rd(adr(10, 0), d); check("R6 event count read-only", d, 32'h0);
      wr(adr(9, 0), 32'h1);
      repeat (4) @(negedge clk);
      wr(adr(9, 0), 32'h0);
      rd(adr(10, 0), d); check("R8 event count advanced", 32'(d != 0), 32'd1);

      // R11 flag raised in the clear cycle survives
      wr(adr(3, 1), 32'd0);
      wr(adr(1, 1), 32'h13);
      wr(adr(1, 1), 32'h02);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = adr(7, 1);
      @(negedge clk);
      d = rd_data;
      check("R11 first read", d, 32'h01);
      @(negedge clk);
      req_valid = 1'b0;
      d = rd_data;
      check("R11 back-to-back read keeps new flag", d, 32'h01);
      wr(adr(1, 1), 32'h03);
      rd(adr(7, 1), d);
      rd(adr(7, 1), d); check("R5 quiet after stop", d, 32'h0);
      @(negedge clk);
      check("R4 idle valid", 32'(rd_valid), 32'd0);
      check("R4 idle data", rd_data, 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule